// File: doc/BRIEF.md
# Data-Cache Allocation and Write Policy Controller

This block sits between a load/store pipeline and the next level of memory. It decides what happens to every data access that does not target a tightly coupled memory. Each request carries its own memory attributes: cacheable, write-allocate, and write-through versus write-back. Together with a global cache enable, these attributes decide whether the access looks up a four-way set-associative cache or goes straight to the next-level port. On a miss that allocates, the controller picks a victim way. A dirty victim is sent to an eviction queue, and a clean one is dropped. The controller then installs the new line. Write hits update the cache. A write-through hit also repeats the write on the next-level port, while a write-back hit only marks the line dirty.

Each line holds one data word. The low address bits select the set and the remaining upper bits form the tag. Only one request is handled at a time. The request port uses a valid/ready handshake, and read data comes back as a single-cycle response pulse. The state machine has these states:

- `ST_IDLE` accepts a request and performs the lookup.
- `ST_EVICT` pushes a dirty victim.
- `ST_FILL_REQ` issues a line fetch and `ST_FILL_WAIT` waits for its data.
- `ST_BUS_REQ` issues a bypass or write-through access and `ST_BUS_WAIT` waits for bypass read data.
- `ST_RESP` returns read data.

Transitions:

- IDLE→RESP: read hit.
- IDLE→EVICT: allocating miss whose victim is dirty.
- IDLE→FILL_REQ: read miss with a clean or empty victim.
- IDLE→BUS_REQ: bypass access, write-through write hit, write miss without allocation, or write-through allocation.
- IDLE→IDLE: write-back hit or write-back allocation.
- EVICT→FILL_REQ, BUS_REQ or IDLE: the path the pending access needs next.
- FILL_REQ→FILL_WAIT and BUS_REQ→BUS_WAIT: on grant, for reads.
- BUS_REQ→IDLE: on grant, for writes.
- FILL_WAIT→RESP and BUS_WAIT→RESP: on read data.
- RESP→IDLE: always.

Top module: `dcache_policy_ctrl`

## Requirements
- R1: When `req_cacheable` is 0 or `cache_en` is 0, the access bypasses the cache. The next-level port issues it with the same address and direction in the cycle after acceptance. A bypass read returns the port's data unchanged, and no cache line is created or modified.
- R2: A cacheable read that misses always allocates a line. The controller fetches the word from the next-level port, returns it, and installs it clean, so a repeat read of that address hits without port traffic.
- R3: A cacheable write that misses with `req_walloc` at 0 is sent to the next-level port as a write and allocates nothing. A later read of that address still misses.
- R4: A cacheable write that misses with `req_walloc` at 1 installs the write data without a next-level read. The installed line is dirty when `req_wthrough` is 0. When `req_wthrough` is 1, the line is clean and the same write is issued on the port.
- R5: A write hit with `req_wthrough` at 1 updates the cached word and issues the same address and data as a next-level write.
- R6: A write hit with `req_wthrough` at 0 updates the cached word and marks it dirty, with no next-level or eviction traffic.
- R7: An allocation takes the lowest-numbered invalid way of the set. When all four ways are valid, it takes the way named by that set's round-robin pointer. Each pointer starts at way 0 after reset and advances by one, wrapping, each time a valid way is replaced.
- R8: When the replaced way is dirty, `ev_valid` pulses for exactly one cycle. The pulse carries the victim's address ({victim tag, set}) and data, and comes before any next-level request for the new access. A clean victim produces no eviction.
- R9: `req_ready` is 0 while a request is in progress. It is also 0 while `ev_full` is 1 and the presented request would allocate. Hits and bypass accesses are accepted regardless of `ev_full`.
- R10: Every accepted read gives exactly one single-cycle `rsp_valid` pulse. For a read hit, the pulse comes in the cycle right after acceptance.
- R11: `nl_req`, `nl_we`, `nl_addr` and `nl_wdata` stay stable until `nl_gnt` is sampled high. Read data for a granted read is taken on `nl_rvalid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cache_en | input | 1 | Global cache enable |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Controller accepts the request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW (12) | Word address: low IW bits set, upper bits tag |
| req_wdata | input | DW (32) | Write data |
| req_cacheable | input | 1 | Location is cacheable |
| req_walloc | input | 1 | Location allocates on write miss |
| req_wthrough | input | 1 | 1 = write-through, 0 = write-back |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_rdata | output | DW (32) | Read data |
| nl_req | output | 1 | Next-level access request |
| nl_we | output | 1 | Next-level access is a write |
| nl_addr | output | AW (12) | Next-level address |
| nl_wdata | output | DW (32) | Next-level write data |
| nl_gnt | input | 1 | Next-level request accepted |
| nl_rvalid | input | 1 | Next-level read data valid |
| nl_rdata | input | DW (32) | Next-level read data |
| ev_full | input | 1 | Eviction queue cannot take an entry |
| ev_valid | output | 1 | Dirty victim push |
| ev_addr | output | AW (12) | Victim address |
| ev_data | output | DW (32) | Victim data |

## Verification
The bench runs attribute mixes against one address. It alternates cacheable with non-cacheable and enabled with disabled, which separates lookups from bypasses: only a lookup turns a repeat read into a silent hit. Write misses with and without write-allocate separate installation from bypass, and write-back versus write-through hits show whether the port stays silent or repeats the write. A set is filled past its four ways after one line has been dirtied, so the order of evictions versus quiet drops exposes the invalid-first and round-robin choice. Holding `ev_full` high against a miss and then against a hit shows that only allocating requests stall.

// File: rtl/dcache_policy_pkg.sv
package dcache_policy_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_EVICT,
        ST_FILL_REQ,
        ST_FILL_WAIT,
        ST_BUS_REQ,
        ST_BUS_WAIT,
        ST_RESP
    } dc_state_e;

    // Path taken once a dirty victim has been pushed out
    typedef enum logic [1:0] {
        AFT_IDLE,
        AFT_FILL,
        AFT_BUS
    } dc_after_e;

endpackage

// File: rtl/dcache_tag_store.sv
module dcache_tag_store #(
    parameter int SETS = 16,
    parameter int WAYS = 4,
    parameter int TW   = 8,
    parameter int DW   = 32,
    parameter int IW   = $clog2(SETS),
    parameter int WW   = $clog2(WAYS)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [IW-1:0]            rd_set,
    output logic [WAYS-1:0]          rd_valid,
    output logic [WAYS-1:0]          rd_dirty,
    output logic [WAYS-1:0][TW-1:0]  rd_tag,
    output logic [WAYS-1:0][DW-1:0]  rd_data,
    output logic [WW-1:0]            rd_rr,
    input  logic                     wr_en,
    input  logic [IW-1:0]            wr_set,
    input  logic [WW-1:0]            wr_way,
    input  logic [TW-1:0]            wr_tag,
    input  logic [DW-1:0]            wr_data,
    input  logic                     wr_dirty,
    input  logic                     rr_adv
);

    logic [WAYS-1:0] valid_q [SETS];
    logic [WAYS-1:0] dirty_q [SETS];
    logic [WW-1:0]   rr_q    [SETS];
    logic [TW-1:0]   tag_q   [SETS][WAYS];
    logic [DW-1:0]   data_q  [SETS][WAYS];

    for (genvar w = 0; w < WAYS; w++) begin : g_rd
        assign rd_tag[w]  = tag_q[rd_set][w];
        assign rd_data[w] = data_q[rd_set][w];
    end
    assign rd_valid = valid_q[rd_set];
    assign rd_dirty = dirty_q[rd_set];
    assign rd_rr    = rr_q[rd_set];

    // State bits that must be known after reset
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                valid_q[s] <= '0;
                dirty_q[s] <= '0;
                rr_q[s]    <= '0;
            end
        end else begin
            if (wr_en) begin
                valid_q[wr_set][wr_way] <= 1'b1;
                dirty_q[wr_set][wr_way] <= wr_dirty;
            end
            if (wr_en && rr_adv) begin
                rr_q[wr_set] <= rr_q[wr_set] + WW'(1);
            end
        end
    end

    // Tag and data arrays need no reset
    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_set][wr_way]  <= wr_tag;
            data_q[wr_set][wr_way] <= wr_data;
        end
    end

endmodule

// File: rtl/dcache_way_sel.sv
module dcache_way_sel #(
    parameter int WAYS = 4,
    parameter int TW   = 8,
    parameter int WW   = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]          valid,
    input  logic [WAYS-1:0][TW-1:0]  tags,
    input  logic [TW-1:0]            look_tag,
    input  logic [WW-1:0]            rr,
    output logic                     hit,
    output logic [WW-1:0]            hit_way,
    output logic [WW-1:0]            vic_way,
    output logic                     vic_was_valid
);

    logic [WAYS-1:0] match;
    logic            any_inv;
    logic [WW-1:0]   inv_way;

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign match[w] = valid[w] && (tags[w] == look_tag);
    end

    always_comb begin
        hit     = 1'b0;
        hit_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (match[w] && !hit) begin
                hit     = 1'b1;
                hit_way = WW'(w);
            end
        end
        // Scan downwards so the lowest free way is the last one written
        any_inv = 1'b0;
        inv_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!valid[w]) begin
                any_inv = 1'b1;
                inv_way = WW'(w);
            end
        end
        vic_way       = any_inv ? inv_way : rr;
        vic_was_valid = !any_inv;
    end

endmodule

// File: rtl/dcache_policy_fsm.sv
module dcache_policy_fsm
    import dcache_policy_pkg::*;
#(
    parameter int AW   = 12,
    parameter int DW   = 32,
    parameter int IW   = 4,
    parameter int WAYS = 4,
    parameter int WW   = $clog2(WAYS),
    parameter int TW   = AW - IW
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cache_en,
    input  logic                     req_valid,
    output logic                     req_ready,
    input  logic                     req_write,
    input  logic [AW-1:0]            req_addr,
    input  logic [DW-1:0]            req_wdata,
    input  logic                     req_cacheable,
    input  logic                     req_walloc,
    input  logic                     req_wthrough,
    output logic                     rsp_valid,
    output logic [DW-1:0]            rsp_rdata,
    output logic                     nl_req,
    output logic                     nl_we,
    output logic [AW-1:0]            nl_addr,
    output logic [DW-1:0]            nl_wdata,
    input  logic                     nl_gnt,
    input  logic                     nl_rvalid,
    input  logic [DW-1:0]            nl_rdata,
    input  logic                     ev_full,
    output logic                     ev_valid,
    output logic [AW-1:0]            ev_addr,
    output logic [DW-1:0]            ev_data,
    input  logic                     hit,
    input  logic [WW-1:0]            hit_way,
    input  logic [WW-1:0]            vic_way,
    input  logic                     vic_was_valid,
    input  logic [WAYS-1:0]          rd_dirty,
    input  logic [WAYS-1:0][TW-1:0]  rd_tag,
    input  logic [WAYS-1:0][DW-1:0]  rd_data,
    output logic                     wr_en,
    output logic [IW-1:0]            wr_set,
    output logic [WW-1:0]            wr_way,
    output logic [TW-1:0]            wr_tag,
    output logic [DW-1:0]            wr_data,
    output logic                     wr_dirty,
    output logic                     rr_adv
);

    dc_state_e      state_q, state_d;
    dc_after_e      after_q;
    logic           op_write;
    logic [AW-1:0]  op_addr;
    logic [DW-1:0]  op_wdata;
    logic [WW-1:0]  op_way;
    logic           op_vicv;
    logic [AW-1:0]  vic_addr_q;
    logic [DW-1:0]  vic_data_q;
    logic [DW-1:0]  rdata_q;

    logic lookup, needs_alloc, victim_dirty, accept;

    assign lookup       = req_cacheable && cache_en;
    assign needs_alloc  = lookup && !hit && (!req_write || req_walloc);
    assign victim_dirty = vic_was_valid && rd_dirty[vic_way];
    assign req_ready    = (state_q == ST_IDLE) && !(needs_alloc && ev_full);
    assign accept       = req_valid && req_ready;
    assign rsp_rdata    = rdata_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    if (!lookup)
                        state_d = ST_BUS_REQ;
                    else if (hit)
                        state_d = !req_write ? ST_RESP
                                : (req_wthrough ? ST_BUS_REQ : ST_IDLE);
                    else if (!req_write)
                        state_d = victim_dirty ? ST_EVICT : ST_FILL_REQ;
                    else if (req_walloc)
                        state_d = victim_dirty ? ST_EVICT
                                : (req_wthrough ? ST_BUS_REQ : ST_IDLE);
                    else
                        state_d = ST_BUS_REQ;
                end
            end
            ST_EVICT: begin
                unique case (after_q)
                    AFT_FILL: state_d = ST_FILL_REQ;
                    AFT_BUS:  state_d = ST_BUS_REQ;
                    default:  state_d = ST_IDLE;
                endcase
            end
            ST_FILL_REQ:  if (nl_gnt)    state_d = ST_FILL_WAIT;
            ST_FILL_WAIT: if (nl_rvalid) state_d = ST_RESP;
            ST_BUS_REQ:   if (nl_gnt)    state_d = op_write ? ST_IDLE : ST_BUS_WAIT;
            ST_BUS_WAIT:  if (nl_rvalid) state_d = ST_RESP;
            ST_RESP:                     state_d = ST_IDLE;
            default:                     state_d = ST_IDLE;
        endcase
    end

    // Captured request, victim and read data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            after_q    <= AFT_IDLE;
            op_write   <= 1'b0;
            op_addr    <= '0;
            op_wdata   <= '0;
            op_way     <= '0;
            op_vicv    <= 1'b0;
            vic_addr_q <= '0;
            vic_data_q <= '0;
            rdata_q    <= '0;
        end else begin
            if (state_q == ST_IDLE && accept) begin
                op_write   <= req_write;
                op_addr    <= req_addr;
                op_wdata   <= req_wdata;
                op_way     <= vic_way;
                op_vicv    <= vic_was_valid;
                vic_addr_q <= {rd_tag[vic_way], req_addr[IW-1:0]};
                vic_data_q <= rd_data[vic_way];
                after_q    <= !req_write ? AFT_FILL
                            : (req_wthrough ? AFT_BUS : AFT_IDLE);
                if (lookup && hit && !req_write)
                    rdata_q <= rd_data[hit_way];
            end
            if ((state_q == ST_FILL_WAIT || state_q == ST_BUS_WAIT) && nl_rvalid)
                rdata_q <= nl_rdata;
        end
    end

    // Outputs
    always_comb begin
        rsp_valid = 1'b0;
        nl_req    = 1'b0;
        nl_we     = 1'b0;
        nl_addr   = '0;
        nl_wdata  = '0;
        ev_valid  = 1'b0;
        ev_addr   = '0;
        ev_data   = '0;
        wr_en     = 1'b0;
        wr_set    = op_addr[IW-1:0];
        wr_way    = op_way;
        wr_tag    = op_addr[AW-1:IW];
        wr_data   = nl_rdata;
        wr_dirty  = 1'b0;
        rr_adv    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (accept && lookup && req_write && (hit || req_walloc)) begin
                    wr_en   = 1'b1;
                    wr_set  = req_addr[IW-1:0];
                    wr_tag  = req_addr[AW-1:IW];
                    wr_data = req_wdata;
                    if (hit) begin
                        wr_way   = hit_way;
                        wr_dirty = rd_dirty[hit_way] || !req_wthrough;
                    end else begin
                        wr_way   = vic_way;
                        wr_dirty = !req_wthrough;
                        rr_adv   = vic_was_valid;
                    end
                end
            end
            ST_EVICT: begin
                ev_valid = 1'b1;
                ev_addr  = vic_addr_q;
                ev_data  = vic_data_q;
            end
            ST_FILL_REQ: begin
                nl_req  = 1'b1;
                nl_addr = op_addr;
            end
            ST_FILL_WAIT: begin
                if (nl_rvalid) begin
                    wr_en  = 1'b1;
                    rr_adv = op_vicv;
                end
            end
            ST_BUS_REQ: begin
                nl_req   = 1'b1;
                nl_we    = op_write;
                nl_addr  = op_addr;
                nl_wdata = op_wdata;
            end
            ST_BUS_WAIT: begin
            end
            ST_RESP: rsp_valid = 1'b1;
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/dcache_policy_ctrl.sv
module dcache_policy_ctrl #(
    parameter int AW   = 12,
    parameter int DW   = 32,
    parameter int SETS = 16,
    parameter int WAYS = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cache_en,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic          req_cacheable,
    input  logic          req_walloc,
    input  logic          req_wthrough,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_rdata,
    output logic          nl_req,
    output logic          nl_we,
    output logic [AW-1:0] nl_addr,
    output logic [DW-1:0] nl_wdata,
    input  logic          nl_gnt,
    input  logic          nl_rvalid,
    input  logic [DW-1:0] nl_rdata,
    input  logic          ev_full,
    output logic          ev_valid,
    output logic [AW-1:0] ev_addr,
    output logic [DW-1:0] ev_data
);

    localparam int IW = $clog2(SETS);
    localparam int WW = $clog2(WAYS);
    localparam int TW = AW - IW;

    logic [WAYS-1:0]          rd_valid, rd_dirty;
    logic [WAYS-1:0][TW-1:0]  rd_tag;
    logic [WAYS-1:0][DW-1:0]  rd_data;
    logic [WW-1:0]            rd_rr;
    logic                     hit, vic_was_valid;
    logic [WW-1:0]            hit_way, vic_way;
    logic                     wr_en, wr_dirty, rr_adv;
    logic [IW-1:0]            wr_set;
    logic [WW-1:0]            wr_way;
    logic [TW-1:0]            wr_tag;
    logic [DW-1:0]            wr_data;

    dcache_tag_store #(.SETS(SETS), .WAYS(WAYS), .TW(TW), .DW(DW), .IW(IW), .WW(WW)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_set   (req_addr[IW-1:0]),
        .rd_valid (rd_valid),
        .rd_dirty (rd_dirty),
        .rd_tag   (rd_tag),
        .rd_data  (rd_data),
        .rd_rr    (rd_rr),
        .wr_en    (wr_en),
        .wr_set   (wr_set),
        .wr_way   (wr_way),
        .wr_tag   (wr_tag),
        .wr_data  (wr_data),
        .wr_dirty (wr_dirty),
        .rr_adv   (rr_adv)
    );

    dcache_way_sel #(.WAYS(WAYS), .TW(TW), .WW(WW)) u_sel (
        .valid         (rd_valid),
        .tags          (rd_tag),
        .look_tag      (req_addr[AW-1:IW]),
        .rr            (rd_rr),
        .hit           (hit),
        .hit_way       (hit_way),
        .vic_way       (vic_way),
        .vic_was_valid (vic_was_valid)
    );

    dcache_policy_fsm #(.AW(AW), .DW(DW), .IW(IW), .WAYS(WAYS), .WW(WW), .TW(TW)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .cache_en      (cache_en),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_write     (req_write),
        .req_addr      (req_addr),
        .req_wdata     (req_wdata),
        .req_cacheable (req_cacheable),
        .req_walloc    (req_walloc),
        .req_wthrough  (req_wthrough),
        .rsp_valid     (rsp_valid),
        .rsp_rdata     (rsp_rdata),
        .nl_req        (nl_req),
        .nl_we         (nl_we),
        .nl_addr       (nl_addr),
        .nl_wdata      (nl_wdata),
        .nl_gnt        (nl_gnt),
        .nl_rvalid     (nl_rvalid),
        .nl_rdata      (nl_rdata),
        .ev_full       (ev_full),
        .ev_valid      (ev_valid),
        .ev_addr       (ev_addr),
        .ev_data       (ev_data),
        .hit           (hit),
        .hit_way       (hit_way),
        .vic_way       (vic_way),
        .vic_was_valid (vic_was_valid),
        .rd_dirty      (rd_dirty),
        .rd_tag        (rd_tag),
        .rd_data       (rd_data),
        .wr_en         (wr_en),
        .wr_set        (wr_set),
        .wr_way        (wr_way),
        .wr_tag        (wr_tag),
        .wr_data       (wr_data),
        .wr_dirty      (wr_dirty),
        .rr_adv        (rr_adv)
    );

endmodule

// File: rtl/dcache_policy_chk.sv
module dcache_policy_chk #(
    parameter int AW = 12,
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cache_en,
    input logic          req_valid,
    input logic          req_ready,
    input logic          req_write,
    input logic [AW-1:0] req_addr,
    input logic          req_cacheable,
    input logic          rsp_valid,
    input logic          nl_req,
    input logic          nl_we,
    input logic [AW-1:0] nl_addr,
    input logic [DW-1:0] nl_wdata,
    input logic          nl_gnt,
    input logic          ev_valid
);

    // R1: an uncached or disabled access appears on the port next cycle
    a_r1_bypass_to_port: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !(req_cacheable && cache_en))
        |=> (nl_req && nl_addr == $past(req_addr) && nl_we == $past(req_write)));

    // R11: an ungranted request holds its fields
    a_r11_port_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (nl_req && !nl_gnt)
        |=> (nl_req && $stable(nl_addr) && $stable(nl_we) && $stable(nl_wdata)));

    // R10: responses are single-cycle pulses
    a_r10_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R8: an eviction push lasts one cycle and is not overlapped by a port request
    a_r8_evict_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        ev_valid |=> !ev_valid);

    a_r8_evict_before_port: assert property (@(posedge clk) disable iff (!rst_n)
        ev_valid |-> !nl_req);

    // R9: no request is taken while one is in progress
    a_r9_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid || rsp_valid || nl_req) |-> !req_ready);

endmodule

bind dcache_policy_ctrl dcache_policy_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cache_en      (cache_en),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_write     (req_write),
    .req_addr      (req_addr),
    .req_cacheable (req_cacheable),
    .rsp_valid     (rsp_valid),
    .nl_req        (nl_req),
    .nl_we         (nl_we),
    .nl_addr       (nl_addr),
    .nl_wdata      (nl_wdata),
    .nl_gnt        (nl_gnt),
    .ev_valid      (ev_valid)
);

// File: tb/dcache_policy_ctrl_test.sv
`timescale 1ns/1ps
module dcache_policy_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cache_en = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [11:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        req_cacheable = 1'b0;
    logic        req_walloc = 1'b0;
    logic        req_wthrough = 1'b0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        nl_req, nl_we;
    logic [11:0] nl_addr;
    logic [31:0] nl_wdata;
    logic        nl_gnt = 1'b0;
    logic        nl_rvalid = 1'b0;
    logic [31:0] nl_rdata = '0;
    logic        ev_full = 1'b0;
    logic        ev_valid;
    logic [11:0] ev_addr;
    logic [31:0] ev_data;

    always #2 clk = ~clk;

    dcache_policy_ctrl uut (.*);

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int acc_cyc = 0;
    bit done = 0;

    typedef struct {
        int          kind;   // 0 eviction, 1 port access, 2 response
        logic        we;
        logic [11:0] addr;
        logic [31:0] data;
        bit          lat;
        string       rq;
    } exp_t;
    exp_t expq[$];

    // Reference cache state
    bit          m_v [16][4];
    bit          m_d [16][4];
    logic [7:0]  m_t [16][4];
    logic [31:0] m_dat [16][4];
    int          m_rr [16];

    function automatic logic [31:0] fmem(logic [11:0] a);
        return {8'h5A, a, ~a};
    endfunction

    function automatic logic [11:0] mk(int t, int s);
        return {t[7:0], s[3:0]};
    endfunction

    task automatic chk(bit ok, string rq, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    function automatic void push(int k, logic we, logic [11:0] a, logic [31:0] d, bit lat, string rq);
        exp_t e;
        e.kind = k; e.we = we; e.addr = a; e.data = d; e.lat = lat; e.rq = rq;
        expq.push_back(e);
    endfunction

    task automatic model(string rq, bit wr, logic [11:0] a, logic [31:0] d, bit c, bit wa, bit wt);
        int s = int'(a[3:0]);
        int hw = -1;
        int vw = -1;
        if (!(c && cache_en)) begin
            push(1, wr, a, wr ? d : 32'h0, 0, rq);
            if (!wr) push(2, 0, a, fmem(a), 0, rq);
            return;
        end
        for (int w = 0; w < 4; w++) if (m_v[s][w] && m_t[s][w] == a[11:4]) hw = w;
        if (hw >= 0) begin
            if (!wr) push(2, 0, a, m_dat[s][hw], 1, rq);
            else begin
                m_dat[s][hw] = d;
                if (wt) push(1, 1, a, d, 0, rq);
                else m_d[s][hw] = 1;
            end
            return;
        end
        if (wr && !wa) begin
            push(1, 1, a, d, 0, rq);
            return;
        end
        for (int w = 0; w < 4; w++) if (!m_v[s][w] && vw < 0) vw = w;
        if (vw < 0) begin
            vw = m_rr[s];
            if (m_d[s][vw]) push(0, 0, {m_t[s][vw], a[3:0]}, m_dat[s][vw], 0, rq);
            m_rr[s] = (m_rr[s] + 1) % 4;
        end
        m_v[s][vw] = 1;
        m_t[s][vw] = a[11:4];
        if (!wr) begin
            push(1, 0, a, 32'h0, 0, rq);
            push(2, 0, a, fmem(a), 0, rq);
            m_dat[s][vw] = fmem(a);
            m_d[s][vw] = 0;
        end else begin
            m_dat[s][vw] = d;
            m_d[s][vw] = !wt;
            if (wt) push(1, 1, a, d, 0, rq);
        end
    endtask

    task automatic do_op(string rq, bit wr, logic [11:0] a, logic [31:0] d, bit c, bit wa, bit wt);
        @(negedge clk);
        req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
        req_cacheable = c; req_walloc = wa; req_wthrough = wt;
        #1;
        while (!req_ready) begin
            @(negedge clk);
            #1;
        end
        model(rq, wr, a, d, c, wa, wt);
        @(posedge clk);
        #1;
        acc_cyc = cyc;
        req_valid = 0;
    endtask

    task automatic drain(string rq);
        int n = 0;
        while ((expq.size() != 0 || !req_ready) && n < 200) begin
            @(negedge clk);
            #1;
            n++;
        end
        chk(expq.size() == 0, rq, "pending expected traffic", expq.size(), 0);
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor and next-level memory model, compared on every clock
    int wait_cnt = 0;
    int rd_cnt = 0;
    logic [11:0] rd_addr = '0;
    always @(negedge clk) begin
        exp_t e;
        nl_gnt = 0;
        nl_rvalid = 0;
        if (rst_n) begin
            if (ev_valid) begin
                if (expq.size() == 0) chk(0, "R8", "unexpected eviction addr", ev_addr, 0);
                else begin
                    e = expq.pop_front();
                    chk(e.kind == 0, e.rq, "eviction out of order, kind", 0, e.kind);
                    chk(ev_addr == e.addr && ev_data == e.data, e.rq, "eviction data",
                        ev_data, e.data);
                end
            end
            if (rsp_valid) begin
                if (expq.size() == 0) chk(0, "R10", "unexpected response", rsp_rdata, 0);
                else begin
                    e = expq.pop_front();
                    chk(e.kind == 2, e.rq, "response out of order, kind", 2, e.kind);
                    chk(rsp_rdata == e.data, e.rq, "read data", rsp_rdata, e.data);
                    if (e.lat) chk(cyc == acc_cyc, "R10", "hit latency cycle", cyc, acc_cyc);
                end
            end
            if (rd_cnt > 0) begin
                rd_cnt--;
                if (rd_cnt == 0) begin
                    nl_rvalid = 1;
                    nl_rdata = fmem(rd_addr);
                end
            end else if (nl_req) begin
                wait_cnt++;
                if (wait_cnt == 2) begin
                    wait_cnt = 0;
                    nl_gnt = 1;
                    if (expq.size() == 0) chk(0, "R11", "unexpected port access", nl_addr, 0);
                    else begin
                        e = expq.pop_front();
                        chk(e.kind == 1, e.rq, "port access out of order, kind", 1, e.kind);
                        chk(nl_we == e.we && nl_addr == e.addr, e.rq, "port we/addr",
                            {19'h0, nl_we, nl_addr}, {19'h0, e.we, e.addr});
                        if (e.we) chk(nl_wdata == e.data, e.rq, "port wdata", nl_wdata, e.data);
                    end
                    if (!nl_we) begin
                        rd_cnt = 2;
                        rd_addr = nl_addr;
                    end
                end
            end else wait_cnt = 0;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R11 watchdog actual=hung expected=complete");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int s = 0; s < 16; s++) begin
            m_rr[s] = 0;
            for (int w = 0; w < 4; w++) begin
                m_v[s][w] = 0; m_d[s][w] = 0; m_t[s][w] = 0; m_dat[s][w] = 0;
            end
        end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        #1;
        // Reset state (R9, R10, R8, R11)
        chk(req_ready == 1, "R9", "ready after reset", req_ready, 1);
        chk(rsp_valid == 0, "R10", "rsp after reset", rsp_valid, 0);
        chk(ev_valid == 0, "R8", "ev after reset", ev_valid, 0);
        chk(nl_req == 0, "R11", "port idle after reset", nl_req, 0);

        // R2: read miss allocates, repeat read hits (R10 latency)
        do_op("R2", 0, mk(1, 1), 0, 1, 0, 0);
        do_op("R2", 0, mk(1, 1), 0, 1, 0, 0);
        drain("R2");

        // R1: non-cacheable read of a new tag, then cacheable read still misses
        do_op("R1", 0, mk(5, 1), 0, 0, 0, 0);
        do_op("R1", 0, mk(5, 1), 0, 1, 0, 0);
        // R1: cache disabled, cached address goes to the port
        cache_en = 0;
        do_op("R1", 0, mk(1, 1), 0, 1, 0, 0);
        do_op("R1", 1, mk(1, 1), 32'hDEAD0001, 1, 1, 0);
        cache_en = 1;
        do_op("R1", 1, mk(9, 2), 32'h0000_1111, 0, 1, 0);
        drain("R1");

        // R3: write miss without allocation, later read still misses
        do_op("R3", 1, mk(2, 2), 32'hCAFE0002, 1, 0, 0);
        do_op("R3", 0, mk(2, 2), 0, 1, 0, 0);
        drain("R3");

        // R4: write-allocate, write-back then write-through
        do_op("R4", 1, mk(2, 3), 32'hB0B00003, 1, 1, 0);
        do_op("R4", 0, mk(2, 3), 0, 1, 0, 0);
        do_op("R4", 1, mk(3, 3), 32'hB0B00004, 1, 1, 1);
        do_op("R4", 0, mk(3, 3), 0, 1, 0, 0);
        drain("R4");

        // R6 and R5: write hits
        do_op("R6", 1, mk(1, 1), 32'h600D0006, 1, 0, 0);
        do_op("R6", 0, mk(1, 1), 0, 1, 0, 0);
        do_op("R5", 1, mk(5, 1), 32'h600D0005, 1, 0, 1);
        do_op("R5", 0, mk(5, 1), 0, 1, 0, 0);
        drain("R5");

        // R7 and R8: fill set 4, dirty way 0, then overflow it
        for (int t = 1; t <= 4; t++) do_op("R7", 0, mk(t, 4), 0, 1, 0, 0);
        do_op("R8", 1, mk(1, 4), 32'hD1D10001, 1, 0, 0);
        do_op("R8", 0, mk(5, 4), 0, 1, 0, 0);
        do_op("R7", 0, mk(6, 4), 0, 1, 0, 0);
        do_op("R8", 1, mk(3, 4), 32'hD1D10003, 1, 0, 0);
        do_op("R8", 1, mk(7, 4), 32'hD1D10007, 1, 1, 0);
        do_op("R7", 0, mk(1, 4), 0, 1, 0, 0);
        do_op("R7", 0, mk(6, 4), 0, 1, 0, 0);
        drain("R7");

        // R9: eviction queue full stalls an allocating miss
        @(negedge clk);
        ev_full = 1;
        req_valid = 1; req_write = 0; req_addr = mk(8, 6); req_cacheable = 1;
        req_walloc = 0; req_wthrough = 0;
        for (int i = 0; i < 4; i++) begin
            #1;
            chk(req_ready == 0, "R9", "stall while queue full", req_ready, 0);
            @(negedge clk);
        end
        // a hit is still accepted while the queue is full
        req_addr = mk(1, 1);
        #1;
        chk(req_ready == 1, "R9", "hit accepted while queue full", req_ready, 1);
        req_valid = 0;
        do_op("R9", 0, mk(1, 1), 0, 1, 0, 0);
        ev_full = 0;
        do_op("R9", 0, mk(8, 6), 0, 1, 0, 0);
        drain("R9");

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule